// File: doc/BRIEF.md
# Parallel-Load Serial-Out Shift Register

This block is an eight-stage shift register that captures a parallel byte and then moves it out one bit at a time. It runs entirely inside one fast system clock domain. Two slow external shift-clock lines are treated as plain data: each is registered once, the two sampled values are combined by OR, and every rising edge of that combined line moves the register one place toward the output. Either line can be held HIGH to block further shifting. However, if the other line is LOW, raising the blocking line is itself a rising edge and shifts the register.

The load control is active low and level sensitive. While it is LOW, every stage copies its parallel input on each system clock and follows any change on those inputs. Load takes priority over any shift edge that is detected in the same cycle. The serial input is registered together with the clock lines and enters stage 0 on a shift. Stage 7 and its complement are the outputs.

The edge detector is a two-state machine. In `ST_LOW` the sampled combined clock was 0 on the previous cycle. In `ST_HIGH` it was 1. The transition `ST_LOW -> ST_HIGH` raises the shift request. The transition `ST_HIGH -> ST_LOW` and the two self-loops raise nothing. The machine advances every cycle, including cycles in which load is active.

Top module: `pls_shifter`

## Requirements
- R1: While `load_n` is 0, one system clock after each edge every stage holds the corresponding bit of `par_in` (bit 7 -> stage 7). The output follows changes of `par_in` during the load.
- R2: If `load_n` is 0 in a cycle in which a shift edge is detected, the parallel value is stored and no shift occurs.
- R3: When `load_n` is 1 and the registered OR of `clk_a` and `clk_b` goes from 0 to 1, the register shifts toward stage 7. Stage 0 takes the registered `ser_in`, and stage n takes stage n-1. The shift becomes visible two system clocks after the pin change.
- R4: With `load_n` at 1 and no such rising edge, all stages keep their values.
- R5: If one clock line is already 1, a rise of the other line causes no shift.
- R6: If one clock line is 0, a rise of the other line causes exactly one shift, the same as a clock edge.
- R7: Releasing `load_n` while a clock line is held at 1 causes no shift.
- R8: A synchronous active-high `rst` clears all stages and the edge history to 0, so `q` is 0 and `q_n` is 1.
- R9: `q` is stage 7, and `q_n` is always its complement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| load_n | input | 1 | Active-low parallel load |
| par_in | input | 8 | Parallel data, bit i to stage i |
| ser_in | input | 1 | Serial data into stage 0 |
| clk_a | input | 1 | External shift clock line A |
| clk_b | input | 1 | External shift clock line B (interchangeable with A) |
| q | output | 1 | Stage 7 |
| q_n | output | 1 | Complement of stage 7 |

## Verification
Load and shift can collide in one cycle. The bench provokes this by pulling `load_n` LOW in exactly the cycle in which a raised clock line reaches the edge detector. It then checks that the parallel byte wins and that no extra shift appears when load is released with the clock still HIGH. The same collisions also occur often under the random stimulus, where load pulses and clock toggles overlap freely. Every cycle is compared against a cycle-level reference model built from the requirements.

// File: rtl/pls_pkg.sv
package pls_pkg;
    typedef enum logic {
        ST_LOW  = 1'b0,
        ST_HIGH = 1'b1
    } edge_state_t;
endpackage

// File: rtl/pls_sync.sv
module pls_sync #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) q[i] <= 1'b0;
            else     q[i] <= d[i];
        end
    end
endmodule

// File: rtl/pls_edge_fsm.sv
module pls_edge_fsm
    import pls_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic line_q,
    output logic rise
);
    edge_state_t state, state_nx;

    always_comb begin
        state_nx = line_q ? ST_HIGH : ST_LOW;
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_LOW;
        else     state <= state_nx;
    end

    always_comb begin
        rise = 1'b0;
        unique case (state)
            ST_LOW:  rise = line_q;
            ST_HIGH: rise = 1'b0;
            default: rise = 1'b0;
        endcase
    end

    assert_single_rise_R3: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);
    assert_rise_needs_high_R5: assert property (@(posedge clk) disable iff (rst)
        $past(line_q) |-> !rise);
endmodule

// File: rtl/pls_shift_core.sv
module pls_shift_core #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_n,
    input  logic [W-1:0] par,
    input  logic         shift_en,
    input  logic         ser,
    output logic         msb
);
    logic [W-1:0] stages;

    always_ff @(posedge clk) begin
        if (rst)           stages <= '0;
        else if (!load_n)  stages <= par;
        else if (shift_en) stages <= {stages[W-2:0], ser};
    end

    assign msb = stages[W-1];

    assert_load_R1: assert property (@(posedge clk) disable iff (rst)
        !load_n |=> stages == $past(par));
    assert_shift_R3: assert property (@(posedge clk) disable iff (rst)
        (load_n && shift_en) |=> stages == {$past(stages[W-2:0]), $past(ser)});
    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (load_n && !shift_en) |=> $stable(stages));
    assert_reset_R8: assert property (@(posedge clk)
        rst |=> stages == '0);
endmodule

// File: rtl/pls_shifter.sv
module pls_shifter #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_n,
    input  logic [WIDTH-1:0] par_in,
    input  logic             ser_in,
    input  logic             clk_a,
    input  logic             clk_b,
    output logic             q,
    output logic             q_n
);
    localparam int NCLK = 2;
    localparam int NSYNC = NCLK + 1;

    logic [NSYNC-1:0] raw, smp;
    logic             line_q;
    logic             rise;
    logic             msb;

    assign raw = {ser_in, clk_b, clk_a};

    pls_sync #(.N(NSYNC)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw),
        .q   (smp)
    );

    assign line_q = |smp[NCLK-1:0];

    pls_edge_fsm u_edge (
        .clk    (clk),
        .rst    (rst),
        .line_q (line_q),
        .rise   (rise)
    );

    pls_shift_core #(.W(WIDTH)) u_core (
        .clk      (clk),
        .rst      (rst),
        .load_n   (load_n),
        .par      (par_in),
        .shift_en (rise),
        .ser      (smp[NCLK]),
        .msb      (msb)
    );

    assign q   = msb;
    assign q_n = ~msb;

    assert_release_no_shift_R7: assert property (@(posedge clk) disable iff (rst)
        ($past(!load_n) && load_n && $past(line_q)) |-> !rise);
    assert_load_wins_R2: assert property (@(posedge clk) disable iff (rst)
        (!load_n && rise) |=> q == $past(par_in[WIDTH-1]));
endmodule

// File: tb/sim_pls_shifter.sv
module sim_pls_shifter;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       load_n = 1'b1;
    logic [7:0] par_in = 8'h00;
    logic       ser_in = 1'b0;
    logic       clk_a = 1'b0;
    logic       clk_b = 1'b0;
    logic       q, q_n;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [7:0] m_st = 8'h00;
    logic m_a = 0, m_b = 0, m_s = 0, m_prev = 0;

    always #5 clk = ~clk;

    pls_shifter u0 (
        .clk(clk), .rst(rst), .load_n(load_n), .par_in(par_in),
        .ser_in(ser_in), .clk_a(clk_a), .clk_b(clk_b), .q(q), .q_n(q_n)
    );

    function automatic logic [7:0] next_stages(logic [7:0] st, logic ld_n,
            logic [7:0] p, logic rise, logic s);
        if (!ld_n)     return p;
        else if (rise) return {st[6:0], s};
        return st;
    endfunction

    task automatic chk(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cyc(string tag);
        logic r;
        @(posedge clk);
        if (rst) begin
            m_st = 0; m_a = 0; m_b = 0; m_s = 0; m_prev = 0;
        end else begin
            r = (m_a | m_b) & ~m_prev;
            m_st = next_stages(m_st, load_n, par_in, r, m_s);
            m_prev = m_a | m_b;
            m_a = clk_a; m_b = clk_b; m_s = ser_in;
        end
        @(negedge clk);
        chk(tag, q, m_st[7]);
        chk("R9", q_n, ~m_st[7]);
    endtask

    task automatic run(string tag, int n);
        for (int i = 0; i < n; i++) cyc(tag);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7));
        @(negedge clk);
        run("R8", 3);
        chk("R8 q", q, 1'b0);
        chk("R8 q_n", q_n, 1'b1);
        rst = 0;

        // R1: load and follow parallel data
        load_n = 0; par_in = 8'hA5; run("R1", 2);
        chk("R1 msb", q, 1'b1);
        par_in = 8'h3C; run("R1", 2);
        chk("R1 follow", q, 1'b0);
        par_in = 8'hA5; run("R1", 1);
        load_n = 1; run("R4", 3);

        // R3: eight shifts with clock A, serial pattern
        for (int k = 0; k < 8; k++) begin
            ser_in = k[0];
            clk_a = 1; run("R3", 2);
            clk_a = 0; run("R3", 2);
        end
        chk("R3 serial", q, 1'b0);

        // R4: hold
        run("R4", 10);

        // R2: load low just as the edge reaches the detector
        clk_b = 1; run("R2", 1);
        load_n = 0; par_in = 8'h55; run("R2", 1);
        // R7: release load while clock B stays high
        load_n = 1; run("R7", 4);
        chk("R7 no shift", q, 1'b0);
        clk_b = 0; run("R4", 3);

        // R6: B low, A rises
        clk_a = 1; run("R6", 3);
        chk("R6 shifted", q, 1'b1);
        clk_a = 0; run("R6", 2);
        // R5: B high first, then A rises
        clk_b = 1; run("R5", 3);
        chk("R5 shifted by B", q, 1'b0);
        clk_a = 1; run("R5", 3);
        chk("R5 inhibited", q, 1'b0);
        clk_a = 0; clk_b = 0; run("R5", 3);

        // random mix
        for (int i = 0; i < 4000; i++) begin
            if (($urandom % 10) == 0) load_n = ~load_n;
            if (($urandom % 4) == 0)  clk_a = ~clk_a;
            if (($urandom % 4) == 0)  clk_b = ~clk_b;
            if (($urandom % 3) == 0)  par_in = 8'($urandom);
            ser_in = 1'($urandom);
            if (($urandom % 500) == 0) rst = 1; else rst = 0;
            cyc("R3");
        end
        rst = 0;

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule